// File: doc/BRIEF.md
# Transmit descriptor ring DMA engine

The engine fetches outgoing frames from a ring of descriptors kept in host memory and sends them as a byte stream. Each descriptor is two 32-bit words, and consecutive descriptors sit 8 bytes apart. The first word carries the control flags and a segment length. The second word carries the address of a buffer segment. A frame may span several descriptors. The engine joins their segments in chain order and sends the result on a byte-wide stream that has a valid/ready handshake and a last flag. When a frame completes, the engine hands the descriptors back to the host and pulses an interrupt for one cycle.

Each frame takes two passes over its chain:
- The first pass reads only the control words. It confirms that every descriptor in the chain is owned by the device, and it adds up the frame length.
- The second pass fetches the buffers and streams them.

On each later descriptor, the second pass zeroes the control word as soon as that descriptor's data has been read. The head descriptor is released last, by rewriting its control word with only the ownership bit cleared. A chain that is not fully owned is therefore abandoned before any byte leaves the engine or any memory is written.

Software sets the ring start address on `ring_base` and loads the descriptor pointer through `ptr_load`/`ptr_value`. After each frame the pointer advances past the chain.

Top module: `txring_dma`

## Requirements
- R1: No frame starts while `run_en` is low, while `ring_base` is zero, or while bit 31 (ownership) of the control word at `desc_ptr` is clear. In those cases the engine makes no memory write, emits no stream beat and raises no interrupt.
- R2: A segment's length is bits 12:0 of the control word. Its bytes are read from whole 32-bit buffer words in big-endian order: bits 31:24 come first. Bytes past the length in the final word are dropped.
- R3: When bit 27 of a control word is set, the frame continues in the next descriptor. That is the ring start if bit 30 (wrap) is set, and otherwise the current address plus 8. After a frame, `desc_ptr` holds the address that follows the chain's last descriptor.
- R4: If a later descriptor in the chain has bit 31 clear, the attempt is dropped. No byte is emitted, no memory is written, no interrupt is raised and `desc_ptr` is unchanged. The chain is tried again once it is fully owned.
- R5: A segment of length zero adds no bytes, but the chain still moves past it. A frame with total length zero emits no beats, yet it is still released and still raises the interrupt.
- R6: Every descriptor after the head has its control word written to zero after its data is fetched. Buffer address words are never written.
- R7: After the last segment, the head's control word is rewritten with only bit 31 cleared. The interrupt then pulses for exactly one cycle, once per frame.
- R8: A frame carries at most `MAX_FRAME` bytes, and any further bytes are dropped. `tx_last` is high only on the frame's final emitted byte.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R10: A memory request holds its address, direction and write data until `mem_ack` is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first ring entry; zero keeps the engine idle |
| run_en | input | 1 | Allows a new frame to start |
| ptr_load | input | 1 | Loads `ptr_value` into the descriptor pointer while idle |
| ptr_value | input | 32 | Descriptor pointer value to load |
| desc_ptr | output | 32 | Current descriptor pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | One-cycle frame completion pulse |

## Verification
The assertions take for granted a set of conditions on the host side:
- The host does not touch descriptors the device owns while a frame is in flight.
- Buffer addresses are word aligned.
- `mem_ack` comes only while a request is pending.
- The pointer is loaded only while the engine is idle.

The bench meets these conditions in two ways. It builds descriptors and loads the pointer only after holding `run_en` low long enough for any poll to finish. Its memory model acknowledges only pending requests, with random extra wait cycles, and every buffer address it places is aligned. Random stalls on `tx_ready` exercise the hold rules.

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int MAX_FRAME = 8192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        run_en,
  input  logic        ptr_load,
  input  logic [31:0] ptr_value,
  output logic [31:0] desc_ptr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int LEN_W = 13;
  localparam int OWN_B = 31;
  localparam int WRAP_B = 30;
  localparam int CONT_B = 27;
  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(MAX_FRAME);

  typedef enum logic [2:0] {IDLE, SCAN, FETCH0, FETCH1, WORD, EMIT, ZERO, RELEASE} st_t;
  st_t st;

  logic [31:0] walk, head_w0, buf_ptr, word;
  logic        seg_wrap, seg_cont, is_head;
  logic [LEN_W-1:0] seg_left;
  logic [1:0]  bidx;
  logic [CNT_W-1:0] total, quota, sat;
  logic [CNT_W+LEN_W-1:0] sum_w;
  logic        step, zero_go;

  function automatic logic [31:0] next_desc(input logic [31:0] a, input logic w, input logic [31:0] b);
    return w ? b : a + 32'd8;
  endfunction

  assign sum_w = {{LEN_W{1'b0}}, total} + {{CNT_W{1'b0}}, mem_rdata[LEN_W-1:0]};
  assign sat   = (sum_w > {{LEN_W{1'b0}}, MAXV}) ? MAXV : sum_w[CNT_W-1:0];

  assign tx_valid = (st == EMIT) && (quota != '0);
  assign tx_last  = tx_valid && (quota == CNT_W'(1));
  assign tx_data  = word[{~bidx, 3'b000} +: 8];
  assign step     = (quota == '0) || tx_ready;
  assign zero_go  = is_head || mem_ack;

  assign mem_req = (st == SCAN) || (st == FETCH0) || (st == FETCH1) || (st == WORD) ||
                   (st == RELEASE) || ((st == ZERO) && !is_head);
  assign mem_we  = (st == ZERO) || (st == RELEASE);
  assign mem_wdata = (st == RELEASE) ? (head_w0 & ~(32'd1 << OWN_B)) : 32'd0;

  always_comb begin
    case (st)
      FETCH1:  mem_addr = walk + 32'd4;
      WORD:    mem_addr = buf_ptr;
      RELEASE: mem_addr = desc_ptr;
      default: mem_addr = walk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; desc_ptr <= '0; walk <= '0; head_w0 <= '0; buf_ptr <= '0;
      word <= '0; seg_wrap <= 1'b0; seg_cont <= 1'b0; is_head <= 1'b1;
      seg_left <= '0; bidx <= '0; total <= '0; quota <= '0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        IDLE: begin
          if (ptr_load) desc_ptr <= ptr_value;
          else if (run_en && ring_base != '0) begin
            st <= SCAN; walk <= desc_ptr; is_head <= 1'b1; total <= '0;
          end
        end
        SCAN: if (mem_ack) begin
          if (!mem_rdata[OWN_B]) st <= IDLE;
          else begin
            if (is_head) head_w0 <= mem_rdata;
            total <= sat;
            if (mem_rdata[CONT_B]) begin
              walk <= next_desc(walk, mem_rdata[WRAP_B], ring_base);
              is_head <= 1'b0;
            end else begin
              quota <= sat; walk <= desc_ptr; is_head <= 1'b1; st <= FETCH0;
            end
          end
        end
        FETCH0: if (mem_ack) begin
          seg_wrap <= mem_rdata[WRAP_B];
          seg_cont <= mem_rdata[CONT_B];
          seg_left <= mem_rdata[LEN_W-1:0];
          st <= FETCH1;
        end
        FETCH1: if (mem_ack) begin
          buf_ptr <= mem_rdata;
          st <= (seg_left == '0) ? ZERO : WORD;
        end
        WORD: if (mem_ack) begin
          word <= mem_rdata; buf_ptr <= buf_ptr + 32'd4; bidx <= '0; st <= EMIT;
        end
        EMIT: if (step) begin
          if (quota != '0) quota <= quota - CNT_W'(1);
          seg_left <= seg_left - LEN_W'(1);
          bidx <= bidx + 2'd1;
          if (seg_left == LEN_W'(1)) st <= ZERO;
          else if (bidx == 2'd3) st <= WORD;
        end
        ZERO: if (zero_go) begin
          walk <= next_desc(walk, seg_wrap, ring_base);
          if (seg_cont) begin is_head <= 1'b0; st <= FETCH0; end
          else st <= RELEASE;
        end
        RELEASE: if (mem_ack) begin
          desc_ptr <= walk; irq <= 1'b1; st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_stream_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_release_clears_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_B]);

  assert_no_beat_at_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !tx_valid && !mem_req);
endmodule

// File: tb/txring_dma_test.sv
module txring_dma_test;
  localparam int MAXF = 24;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] OWN = 32'h8000_0000, WRAP = 32'h4000_0000, CONT = 32'h0800_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] ring_base = BASE, ptr_value = 0, mem_rdata = 0;
  logic run_en = 0, ptr_load = 0, mem_ack = 0, tx_ready = 1;
  logic [31:0] desc_ptr, mem_addr, mem_wdata;
  logic mem_req, mem_we, tx_valid, tx_last, irq;
  logic [7:0] tx_data;

  txring_dma #(.MAX_FRAME(MAXF)) uut (.*);

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:511];
  logic [7:0]  got [0:63];
  int ngot = 0, nlast = 0, lastidx = -1, irq_cnt = 0, wr_cnt = 0;
  int tests = 0, fails = 0;
  logic stall = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'((a * 13) + (a >> 8) + 5);
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
    if (mem_req && (!stall || lfsr[1])) begin
      mem_ack = 1;
      if (mem_we) begin mem[mem_addr[10:2]] = mem_wdata; wr_cnt++; end
      else mem_rdata = mem[mem_addr[10:2]];
    end else mem_ack = 0;
    if (tx_valid && tx_ready) begin
      if (ngot < 64) got[ngot] = tx_data;
      if (tx_last) begin nlast++; lastidx = ngot; end
      ngot++;
    end
    if (irq) irq_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_and_load(input logic [31:0] p);
    run_en = 0; cyc(30);
    ptr_value = p; ptr_load = 1; cyc(1); ptr_load = 0; cyc(1);
    ngot = 0; nlast = 0; lastidx = -1;
  endtask

  logic [31:0] orig0 [0:7], orig1 [0:7];
  int seg_len [0:7];

  task automatic run_frame(input int start, input int n);
    int total, exp_len, irq0, mism;
    logic [7:0] exp_b [0:63];
    run_en = 0; cyc(30);
    total = 0;
    for (int k = 0; k < n; k++) begin
      int idx;
      logic [31:0] w0, w1;
      idx = (start + k) % 8;
      w1 = 32'h400 + 32'h80 * k;
      w0 = OWN | (idx == 7 ? WRAP : 0) | (k < n - 1 ? CONT : 0) | 32'(seg_len[k]);
      mem[(BASE + 8 * idx) >> 2] = w0;
      mem[((BASE + 8 * idx) >> 2) + 1] = w1;
      orig0[k] = w0; orig1[k] = w1;
      for (int b = 0; b < seg_len[k]; b++) begin
        if (total < 64) exp_b[total] = pat(w1 + b);
        total++;
      end
    end
    mem[(BASE + 8 * ((start + n) % 8)) >> 2] = 0;
    exp_len = total > MAXF ? MAXF : total;
    settle_and_load(BASE + 8 * start);
    irq0 = irq_cnt;
    run_en = 1;
    for (int t = 0; t < 3000 && irq_cnt == irq0; t++) cyc(1);
    run_en = 0; cyc(10);
    chk("R7 one irq per frame", irq_cnt, irq0 + 1);
    chk("R8 R5 frame byte count", ngot, exp_len);
    mism = 0;
    for (int i = 0; i < exp_len && i < 64; i++) if (got[i] !== exp_b[i]) mism++;
    chk("R2 byte order and content mismatches", mism, 0);
    chk("R8 last flag count", nlast, exp_len > 0 ? 1 : 0);
    if (exp_len > 0) chk("R8 last flag position", lastidx, exp_len - 1);
    chk("R7 head released", mem[(BASE + 8 * start) >> 2], orig0[0] & ~OWN);
    mism = 0;
    for (int k = 1; k < n; k++) if (mem[(BASE + 8 * ((start + k) % 8)) >> 2] !== 0) mism++;
    chk("R6 later control words zeroed", mism, 0);
    mism = 0;
    for (int k = 0; k < n; k++) if (mem[((BASE + 8 * ((start + k) % 8)) >> 2) + 1] !== orig1[k]) mism++;
    chk("R6 address words untouched", mism, 0);
    chk("R3 pointer after chain", desc_ptr, BASE + 8 * ((start + n) % 8));
  endtask

  task automatic expect_quiet(input string tag, input logic [31:0] p);
    int w0, i0;
    w0 = wr_cnt; i0 = irq_cnt;
    cyc(150);
    chk({tag, " no writes"}, wr_cnt, w0);
    chk({tag, " no irq"}, irq_cnt, i0);
    chk({tag, " no beats"}, ngot, 0);
    chk({tag, " pointer held"}, desc_ptr, p);
  endtask

  initial begin
    int l4 [0:3];
    for (int i = 0; i < 512; i++) mem[i] = 0;
    for (int a = 32'h400; a < 32'h800; a += 4)
      mem[a >> 2] = {pat(a), pat(a + 1), pat(a + 2), pat(a + 3)};
    cyc(4);
    chk("R1 reset no request", mem_req, 0);
    chk("R1 reset no valid", tx_valid, 0);
    chk("R7 reset no irq", irq, 0);
    rst_n = 1; cyc(2);
    chk("R1 reset pointer", desc_ptr, 0);

    mem[(BASE + 8) >> 2] = OWN | 32'd5; mem[((BASE + 8) >> 2) + 1] = 32'h400;
    settle_and_load(BASE + 8);
    expect_quiet("R1 disabled", BASE + 8);
    ring_base = 0; run_en = 1;
    expect_quiet("R1 zero ring base", BASE + 8);
    run_en = 0; ring_base = BASE;
    mem[(BASE + 8) >> 2] = 32'd5;
    run_en = 1;
    expect_quiet("R1 head not owned", BASE + 8);

    run_en = 0; cyc(30);
    mem[(BASE + 16) >> 2] = OWN | CONT | 32'd6; mem[((BASE + 16) >> 2) + 1] = 32'h400;
    mem[(BASE + 24) >> 2] = 32'd3;              mem[((BASE + 24) >> 2) + 1] = 32'h480;
    settle_and_load(BASE + 16);
    run_en = 1;
    expect_quiet("R4 later not owned", BASE + 16);
    chk("R4 head untouched", mem[(BASE + 16) >> 2], OWN | CONT | 32'd6);
    chk("R4 later untouched", mem[(BASE + 24) >> 2], 32'd3);
    mem[(BASE + 32) >> 2] = 0;
    mem[(BASE + 24) >> 2] = OWN | 32'd3;
    for (int t = 0; t < 2000 && desc_ptr != BASE + 32; t++) cyc(1);
    cyc(10);
    chk("R4 retry emits frame", ngot, 9);
    chk("R4 retry pointer", desc_ptr, BASE + 32);

    for (int len = 0; len < 10; len++) begin
      stall = len[0];
      seg_len[0] = len;
      run_frame(len % 8, 1);
    end
    l4 = '{0, 1, 4, 7};
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        stall = (a + b) % 2 == 1;
        seg_len[0] = l4[a]; seg_len[1] = l4[b];
        run_frame((a * 4 + b) % 8, 2);
      end
    stall = 1;
    seg_len[0] = 5;  seg_len[1] = 0;  seg_len[2] = 6;  run_frame(6, 3);
    seg_len[0] = 0;  seg_len[1] = 0;  seg_len[2] = 0;  run_frame(2, 3);
    seg_len[0] = 8;  seg_len[1] = 8;  seg_len[2] = 8;  run_frame(5, 3);
    stall = 0;
    seg_len[0] = 10; seg_len[1] = 10; seg_len[2] = 10; run_frame(7, 3);
    seg_len[0] = 9;  seg_len[1] = 8;  seg_len[2] = 8;  run_frame(0, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule